// File: doc/BRIEF.md
# Channel Length Timer

This block is the automatic shut-off timer of one tone channel in a sound generator. Software writes a length value, and can enable length counting and trigger the channel through a control write. While counting is enabled, a 256 Hz tick from the frame sequencer wears the remaining count down. When the count runs out, the block raises a one-cycle pulse that tells the channel to switch itself off. The parameter `MAX_LEN` sets the full length: 64 for the square and noise channels, 256 for the wave channel.

Two edge cases come from the timing of control writes. The frame sequencer says whether its next step will clock length. If a control write lands in a window where it will not, two things change. Turning length counting on from off takes one extra count away at once. A trigger that reloads an exhausted counter while counting is enabled loads one less than the full length. A power-down input clears the count and the enable bit.

Top module: `lenTimer`

## Requirements
- R1: A length-load write sets the remaining count to `MAX_LEN` minus the written value. The value is 6 bits wide for `MAX_LEN`=64 and 8 bits wide for `MAX_LEN`=256.
- R2: While counting is enabled, each tick lowers a non-zero count by one. The tick that brings the count to zero causes `chanOff` to be high for exactly one cycle, in the cycle after that tick.
- R3: While counting is disabled, ticks leave the count unchanged. The enable bit of a control write takes effect from that write on.
- R4: A trigger that finds the count at zero reloads it to `MAX_LEN`, so a full run lasts 64 ticks (or 256 ticks). A count of zero with counting enabled never raises `chanOff` on a tick.
- R5: A trigger that finds a non-zero count leaves the count as it is.
- R6: A control write with `nextSkipsLen` high takes one extra count away when three things hold: counting was disabled before the write, the write enables it, and the count is non-zero. Without these conditions no extra count is taken.
- R7: If that extra count brings the count to zero and the trigger bit of the same write is clear, `chanOff` pulses in the next cycle.
- R8: A trigger with `nextSkipsLen` high and the enable bit set, whose reload starts from zero, loads `MAX_LEN`-1 instead of `MAX_LEN`. This also applies when the zero was reached by the extra count of R6 in the same write, and in that case no `chanOff` pulse is made. With the enable bit clear, the reload is `MAX_LEN`.
- R9: `powerOff` clears the count and the enable bit and produces no `chanOff` pulse.
- R10: A tick that arrives in the same cycle as a length-load write or a control write is not applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenTick | input | 1 | 256 Hz length tick from the frame sequencer, one cycle wide |
| nextSkipsLen | input | 1 | High when the next sequencer step will not clock length |
| loadWr | input | 1 | Length-load write strobe |
| loadVal | input | $clog2(MAX_LEN) | Written length value |
| ctrlWr | input | 1 | Control write strobe |
| ctrlLenEn | input | 1 | Length-enable bit of the control write |
| ctrlTrig | input | 1 | Trigger bit of the control write |
| powerOff | input | 1 | Sound unit power-off clear |
| chanOff | output | 1 | One-cycle channel-disable pulse |

## Verification
The extra count from enabling in a quiet window and the trigger reload can fall in the same control write. The bench provokes this by loading a count of one, with counting disabled, and then writing enable plus trigger while `nextSkipsLen` is high. It judges the outcome by two observations: no `chanOff` pulse may follow, and the next expiry must come after exactly `MAX_LEN`-1 ticks. The same write without the trigger bit must give a pulse in the very next cycle. A second collision is a tick in the same cycle as a write, which must not move the count; the bench checks this through the length of the following run.

// File: rtl/lenPkg.sv
package lenPkg;
  // Strobes the control sends to the counter datapath each cycle.
  typedef struct packed {
    logic clear;        // power-off: count to zero
    logic reloadShort;  // trigger in quiet window: count to max-1
    logic reloadFull;   // trigger from zero: count to max
    logic extraDec;     // enable in quiet window: one extra count
    logic tickDec;      // normal tick decrement
  } lenStrobe_t;
endpackage

// File: rtl/lenDatapath.sv
module lenDatapath
  import lenPkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LOAD_W = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadWr,
  input  logic [LOAD_W-1:0] loadVal,
  input  lenStrobe_t        strobe,
  output logic              baseZero,
  output logic              baseOne,
  output logic              cntZero,
  output logic              cntOne,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] SHORT = CNT_W'(MAX_LEN - 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic [CNT_W-1:0] baseCnt;

  // A length load in this cycle is what the control write sees.
  assign baseCnt  = loadWr ? (FULL - CNT_W'(loadVal)) : cntQ;
  assign baseZero = (baseCnt == '0);
  assign baseOne  = (baseCnt == CNT_W'(1));
  assign cntZero  = (cntQ == '0);
  assign cntOne   = (cntQ == CNT_W'(1));

  always_comb begin
    cntD = baseCnt;
    if (strobe.clear)            cntD = '0;
    else if (strobe.reloadShort) cntD = SHORT;
    else if (strobe.reloadFull)  cntD = FULL;
    else if (strobe.extraDec)    cntD = baseCnt - CNT_W'(1);
    else if (strobe.tickDec)     cntD = cntQ - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntD;
  end

  assign cnt = cntQ;
endmodule

// File: rtl/lenControl.sv
module lenControl
  import lenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lenTick,
  input  logic       nextSkipsLen,
  input  logic       loadWr,
  input  logic       ctrlWr,
  input  logic       ctrlLenEn,
  input  logic       ctrlTrig,
  input  logic       powerOff,
  input  logic       baseZero,
  input  logic       baseOne,
  input  logic       cntZero,
  input  logic       cntOne,
  output lenStrobe_t strobe,
  output logic       lenEn,
  output logic       chanOff
);
  logic enQ;
  logic extraHit;
  logic extraToZero;
  logic reloadHit;
  logic tickHit;
  logic killNow;

  always_comb begin
    extraHit    = !powerOff && ctrlWr && nextSkipsLen && !enQ && ctrlLenEn && !baseZero;
    extraToZero = extraHit && baseOne;
    reloadHit   = !powerOff && ctrlWr && ctrlTrig && (baseZero || extraToZero);
    tickHit     = !powerOff && lenTick && !ctrlWr && !loadWr && enQ && !cntZero;
    killNow     = (extraToZero && !ctrlTrig) || (tickHit && cntOne);

    strobe.clear       = powerOff;
    strobe.reloadShort = reloadHit && nextSkipsLen && ctrlLenEn;
    strobe.reloadFull  = reloadHit && !(nextSkipsLen && ctrlLenEn);
    strobe.extraDec    = extraHit;
    strobe.tickDec     = tickHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      chanOff <= 1'b0;
    end else begin
      chanOff <= killNow;
      if (powerOff)    enQ <= 1'b0;
      else if (ctrlWr) enQ <= ctrlLenEn;
    end
  end

  assign lenEn = enQ;
endmodule

// File: rtl/lenTimer.sv
module lenTimer
  import lenPkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LOAD_W = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenTick,
  input  logic              nextSkipsLen,
  input  logic              loadWr,
  input  logic [LOAD_W-1:0] loadVal,
  input  logic              ctrlWr,
  input  logic              ctrlLenEn,
  input  logic              ctrlTrig,
  input  logic              powerOff,
  output logic              chanOff
);
  lenStrobe_t       strobe;
  logic             baseZero;
  logic             baseOne;
  logic             cntZero;
  logic             cntOne;
  logic             lenEn;
  logic [CNT_W-1:0] cnt;

  lenControl ctrl (
    .clk(clk), .rstN(rstN), .lenTick(lenTick), .nextSkipsLen(nextSkipsLen),
    .loadWr(loadWr), .ctrlWr(ctrlWr), .ctrlLenEn(ctrlLenEn), .ctrlTrig(ctrlTrig),
    .powerOff(powerOff), .baseZero(baseZero), .baseOne(baseOne),
    .cntZero(cntZero), .cntOne(cntOne), .strobe(strobe), .lenEn(lenEn),
    .chanOff(chanOff)
  );

  lenDatapath #(.MAX_LEN(MAX_LEN)) dp (
    .clk(clk), .rstN(rstN), .loadWr(loadWr), .loadVal(loadVal), .strobe(strobe),
    .baseZero(baseZero), .baseOne(baseOne), .cntZero(cntZero), .cntOne(cntOne),
    .cnt(cnt)
  );
endmodule

// File: rtl/lenTimerChecker.sv
module lenTimerChecker #(
  parameter int MAX_LEN = 64,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             lenTick,
  input logic             nextSkipsLen,
  input logic             loadWr,
  input logic             ctrlWr,
  input logic             ctrlLenEn,
  input logic             ctrlTrig,
  input logic             powerOff,
  input logic             chanOff,
  input logic             lenEn,
  input logic [CNT_W-1:0] cnt
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    chanOff |=> !chanOff);

  assert_pulse_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    chanOff |-> (cnt == '0));

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lenTick && lenEn && cnt > CNT_W'(1) && !ctrlWr && !loadWr && !powerOff)
    |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lenEn && !ctrlWr && !loadWr && !powerOff) |=> (cnt == $past(cnt)));

  assert_short_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlTrig && ctrlLenEn && nextSkipsLen && !loadWr && !powerOff && cnt == '0)
    |=> (cnt == CNT_W'(MAX_LEN - 1) && !chanOff));

  assert_power_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerOff |=> (cnt == '0 && !lenEn && !chanOff));

  assert_write_no_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lenTick && ctrlWr && !ctrlTrig && !nextSkipsLen && !loadWr && !powerOff)
    |=> (cnt == $past(cnt)));

  always_ff @(posedge clk) begin
    if (rstN) begin
      assert_count_bound_R4: assert (cnt <= CNT_W'(MAX_LEN));
    end
  end
endmodule

bind lenTimer lenTimerChecker #(.MAX_LEN(MAX_LEN)) lenChk (
  .clk(clk), .rstN(rstN), .lenTick(lenTick), .nextSkipsLen(nextSkipsLen),
  .loadWr(loadWr), .ctrlWr(ctrlWr), .ctrlLenEn(ctrlLenEn), .ctrlTrig(ctrlTrig),
  .powerOff(powerOff), .chanOff(chanOff), .lenEn(lenEn), .cnt(cnt)
);

// File: tb/lenTimer_test.sv
module lenTimer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lenTick = 1'b0;
  logic nextSkipsLen = 1'b0;
  logic loadWr = 1'b0;
  logic [5:0] loadValSq = '0;
  logic [7:0] loadValWv = '0;
  logic ctrlWr = 1'b0;
  logic ctrlLenEn = 1'b0;
  logic ctrlTrig = 1'b0;
  logic powerOff = 1'b0;
  logic chanOffSq;
  logic chanOffWv;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lenTimer #(.MAX_LEN(64)) uut (
    .clk(clk), .rstN(rstN), .lenTick(lenTick), .nextSkipsLen(nextSkipsLen),
    .loadWr(loadWr), .loadVal(loadValSq), .ctrlWr(ctrlWr), .ctrlLenEn(ctrlLenEn),
    .ctrlTrig(ctrlTrig), .powerOff(powerOff), .chanOff(chanOffSq)
  );

  lenTimer #(.MAX_LEN(256)) uutWave (
    .clk(clk), .rstN(rstN), .lenTick(lenTick), .nextSkipsLen(nextSkipsLen),
    .loadWr(loadWr), .loadVal(loadValWv), .ctrlWr(ctrlWr), .ctrlLenEn(ctrlLenEn),
    .ctrlTrig(ctrlTrig), .powerOff(powerOff), .chanOff(chanOffWv)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic clean();
    powerOff = 1'b1;
    @(negedge clk);
    powerOff = 1'b0;
  endtask

  task automatic doLoad(input logic [5:0] vSq, input logic [7:0] vWv, input logic tick);
    loadWr = 1'b1; loadValSq = vSq; loadValWv = vWv; lenTick = tick;
    @(negedge clk);
    loadWr = 1'b0; lenTick = 1'b0;
  endtask

  task automatic doCtrl(input logic en, input logic trig, input logic quiet, input logic tick);
    ctrlWr = 1'b1; ctrlLenEn = en; ctrlTrig = trig; nextSkipsLen = quiet; lenTick = tick;
    @(negedge clk);
    ctrlWr = 1'b0; ctrlTrig = 1'b0; nextSkipsLen = 1'b0; lenTick = 1'b0;
  endtask

  // Ticks every cycle; reports the tick index of the first pulse per instance (0 = none).
  task automatic countTicks(input int limit, output int nSq, output int nWv);
    nSq = 0; nWv = 0;
    for (int i = 1; i <= limit; i++) begin
      lenTick = 1'b1;
      @(negedge clk);
      lenTick = 1'b0;
      if (chanOffSq && nSq == 0) nSq = i;
      if (chanOffWv && nWv == 0) nWv = i;
    end
  endtask

  task automatic testReset();
    int a, b;
    check("R9 reset pulse sq", chanOffSq, 0);
    check("R9 reset pulse wv", chanOffWv, 0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    countTicks(300, a, b);
    check("R4 zero count no expiry sq", a, 0);
    check("R4 zero count no expiry wv", b, 0);
    doCtrl(1'b1, 1'b1, 1'b0, 1'b0);
    countTicks(300, a, b);
    check("R4 full run sq", a, 64);
    check("R4 full run wv", b, 256);
  endtask

  task automatic testLoad();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    countTicks(4, a, b);
    check("R1 loaded run sq", a, 4);
    check("R1 loaded run wv", b, 4);
    @(negedge clk);
    check("R2 pulse one cycle sq", chanOffSq, 0);
    check("R2 pulse one cycle wv", chanOffWv, 0);
  endtask

  task automatic testDisabled();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b0, 1'b0, 1'b0, 1'b0);
    countTicks(10, a, b);
    check("R3 disabled sq", a, 0);
    check("R3 disabled wv", b, 0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    countTicks(10, a, b);
    check("R3 count kept sq", a, 4);
    check("R3 count kept wv", b, 4);
  endtask

  task automatic testExtra();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b1, 1'b0);
    countTicks(10, a, b);
    check("R6 extra count sq", a, 3);
    check("R6 extra count wv", b, 3);
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b1, 1'b0);
    countTicks(10, a, b);
    check("R6 already enabled sq", a, 4);
    check("R6 already enabled wv", b, 4);
  endtask

  task automatic testExtraKill();
    clean();
    doLoad(6'd63, 8'd255, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 extra kill sq", chanOffSq, 1);
    check("R7 extra kill wv", chanOffWv, 1);
    @(negedge clk);
    check("R7 kill one cycle sq", chanOffSq, 0);
  endtask

  task automatic testTrigKeep();
    int a, b;
    clean();
    doLoad(6'd63, 8'd255, 1'b0);
    doCtrl(1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 trigger keeps on sq", chanOffSq, 0);
    check("R8 trigger keeps on wv", chanOffWv, 0);
    countTicks(300, a, b);
    check("R8 short after extra sq", a, 63);
    check("R8 short after extra wv", b, 255);
  endtask

  task automatic testQuietTrig();
    int a, b;
    clean();
    doCtrl(1'b1, 1'b1, 1'b0, 1'b0);
    countTicks(300, a, b);
    doCtrl(1'b1, 1'b1, 1'b1, 1'b0);
    countTicks(300, a, b);
    check("R8 quiet reload sq", a, 63);
    check("R8 quiet reload wv", b, 255);
    clean();
    doCtrl(1'b0, 1'b1, 1'b1, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    countTicks(300, a, b);
    check("R8 quiet disabled full sq", a, 64);
    check("R8 quiet disabled full wv", b, 256);
  endtask

  task automatic testTrigNonzero();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b1, 1'b0, 1'b0);
    countTicks(10, a, b);
    check("R5 trigger nonzero sq", a, 4);
    check("R5 trigger nonzero wv", b, 4);
  endtask

  task automatic testPower();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    clean();
    check("R9 no pulse on power-off", chanOffSq, 0);
    doLoad(6'd60, 8'd252, 1'b0);
    countTicks(10, a, b);
    check("R9 enable cleared sq", a, 0);
    check("R9 enable cleared wv", b, 0);
    clean();
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    countTicks(300, a, b);
    check("R9 count cleared sq", a, 0);
    check("R9 count cleared wv", b, 0);
  endtask

  task automatic testTickWrite();
    int a, b;
    clean();
    doLoad(6'd60, 8'd252, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b0);
    doCtrl(1'b1, 1'b0, 1'b0, 1'b1);
    doLoad(6'd60, 8'd252, 1'b1);
    countTicks(10, a, b);
    check("R10 tick with write sq", a, 4);
    check("R10 tick with write wv", b, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testDisabled();
    testExtra();
    testExtraKill();
    testTrigKeep();
    testQuietTrig();
    testTrigNonzero();
    testPower();
    testTickWrite();
    finishRun();
  end
endmodule